// File: doc/BRIEF.md
# System Management Interrupt Cause Collector

The block gathers eight asynchronous, level-style cause lines and folds them into a single system management interrupt output. The causes are:

- five interrupt request lines;
- a power-down timer expiry;
- an external interrupt pin;
- a strobe for writes to a power-management command port.

Each cause line passes through a synchronizer. Its rising edge then sets a sticky status bit. Software clears a status bit by writing zero to it. A cause that is still held high therefore cannot set its bit again until it drops and rises once more.

Each status bit has a matching enable bit. A global gate bit in a control register must be set before any enabled, pending status bit can drive the output. All three registers sit behind a simple synchronous register port. A write lands on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `smiCauseHub`

## Requirements
- R1: After reset the enable, status and control registers all read zero and `smiOut` is low.
- R2: Address 0 is the enable register. Bits 7:0 hold enables in this order from bit 0: IRQ1, IRQ3, IRQ4, IRQ8, IRQ12, timer expiry, external pin, command-port write. Bits 15:8 ignore writes and read as zero.
- R3: Address 1 is the status register, using the same bit order as the enable register (`causeIn[k]` maps to bit k). A low-to-high change on `causeIn[k]` sets status bit k, readable at the fourth falling clock edge after the change.
- R4: Status bits respond to edges, not levels. A bit cleared while its cause stays high stays clear. It sets again only after the cause goes low and then high again.
- R5: Writing 0 to a status bit clears it. Writing 1 leaves it as it was.
- R6: If a rising edge reaches a status bit in the same cycle as a write of 0 to that bit, the bit ends up set.
- R7: Address 2 is the control register. Bit 0 is the gate, and bits 15:1 read as zero. `smiOut` is high exactly when the gate is 1 and some status bit is set together with its enable bit.
- R8: A status bit latches its cause whatever the state of its enable bit or the gate.
- R9: Address 3 is unmapped. It reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeIn | input | 8 | Asynchronous cause levels, bit order as in R2 |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| smiOut | output | 1 | System management interrupt request |

## Verification
The assertions assume two things about the inputs: each cause holds a level for at least a few clocks, and at most one register write arrives per cycle. On that basis they check only the synchronized edges against the status register.

The stimulus changes causes and register signals on falling clock edges only. After every cause change it waits at least four cycles, which lets the synchronizer and the edge detector settle before the next sample.

The one deliberate collision is the set-versus-clear case (R6). There the clearing write is timed to the exact edge on which the synchronized rise reaches the status register.

// File: rtl/smiHubPkg.sv
package smiHubPkg;

  // Register addresses
  localparam int ADDR_ENABLE  = 0;
  localparam int ADDR_STATUS  = 1;
  localparam int ADDR_CONTROL = 2;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrEnable;
    logic wrStatus;
    logic wrControl;
  } smiStrobes_t;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } readSel_t;

endpackage

// File: rtl/smiHubCtrl.sv
module smiHubCtrl
  import smiHubPkg::*;
#(
  parameter int ADDR_WIDTH = 2
) (
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  output smiStrobes_t           strb,
  output readSel_t              readSel
);

  logic hitEnable;
  logic hitStatus;
  logic hitControl;

  assign hitEnable  = (int'(regAddr) == ADDR_ENABLE);
  assign hitStatus  = (int'(regAddr) == ADDR_STATUS);
  assign hitControl = (int'(regAddr) == ADDR_CONTROL);

  always_comb begin
    strb.wrEnable  = regWrEn & hitEnable;
    strb.wrStatus  = regWrEn & hitStatus;
    strb.wrControl = regWrEn & hitControl;
    if (hitEnable)       readSel = SEL_ENABLE;
    else if (hitStatus)  readSel = SEL_STATUS;
    else if (hitControl) readSel = SEL_CONTROL;
    else                 readSel = SEL_NONE;
  end

endmodule

// File: rtl/smiHubDatapath.sv
module smiHubDatapath
  import smiHubPkg::*;
#(
  parameter int NUM_CAUSES  = 8,
  parameter int REG_WIDTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CAUSES-1:0] causeIn,
  input  smiStrobes_t           strb,
  input  readSel_t              readSel,
  input  logic [REG_WIDTH-1:0]  wrData,
  output logic [REG_WIDTH-1:0]  rdData,
  output logic                  smiOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_CAUSES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_CAUSES-1:0] prevQ;
  logic [NUM_CAUSES-1:0] riseVec;
  logic [NUM_CAUSES-1:0] enableQ;
  logic [NUM_CAUSES-1:0] statusQ;
  logic [NUM_CAUSES-1:0] statusKeep;
  logic                  gateQ;

  // Synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= causeIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // Edge detection on the synchronized causes
  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else prevQ <= syncQ[LAST_STAGE];
  end

  assign riseVec = syncQ[LAST_STAGE] & ~prevQ;

  // A written zero clears; a rising edge in the same cycle wins
  assign statusKeep = strb.wrStatus ? wrData[NUM_CAUSES-1:0] : '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      gateQ   <= 1'b0;
    end else begin
      statusQ <= (statusQ & statusKeep) | riseVec;
      if (strb.wrEnable)  enableQ <= wrData[NUM_CAUSES-1:0];
      if (strb.wrControl) gateQ   <= wrData[0];
    end
  end

  assign smiOut = gateQ & (|(statusQ & enableQ));

  always_comb begin
    rdData = '0;
    case (readSel)
      SEL_ENABLE:  rdData[NUM_CAUSES-1:0] = enableQ;
      SEL_STATUS:  rdData[NUM_CAUSES-1:0] = statusQ;
      SEL_CONTROL: rdData[0] = gateQ;
      default:     rdData = '0;
    endcase
  end

  generate
    if (REG_WIDTH > NUM_CAUSES) begin : gSpare
      logic unusedHiBits;
      assign unusedHiBits = ^wrData[REG_WIDTH-1:NUM_CAUSES];
    end
  endgenerate

  // R3
  rise_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((statusQ & $past(riseVec)) == $past(riseVec)));

  // R4
  set_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN) |=> ((statusQ & ~$past(statusQ) & ~$past(riseVec)) == '0));

  // R5
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrStatus) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnable |=> (enableQ == $past(wrData[NUM_CAUSES-1:0])));

  // R7
  gate_blocks_smi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateQ) |-> (!smiOut));

endmodule

// File: rtl/smiCauseHub.sv
module smiCauseHub
  import smiHubPkg::*;
#(
  parameter int NUM_CAUSES  = 8,
  parameter int REG_WIDTH   = 16,
  parameter int ADDR_WIDTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CAUSES-1:0] causeIn,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_WIDTH-1:0]  regWrData,
  output logic [REG_WIDTH-1:0]  regRdData,
  output logic                  smiOut
);

  smiStrobes_t strb;
  readSel_t    readSel;

  smiHubCtrl #(.ADDR_WIDTH(ADDR_WIDTH)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb),
    .readSel (readSel)
  );

  smiHubDatapath #(
    .NUM_CAUSES  (NUM_CAUSES),
    .REG_WIDTH   (REG_WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .causeIn (causeIn),
    .strb    (strb),
    .readSel (readSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .smiOut  (smiOut)
  );

endmodule

// File: tb/smiCauseHub_bench.sv
`timescale 1ns/1ps
module smiCauseHub_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  causeIn;
  logic [1:0]  regAddr;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        smiOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  smiCauseHub u_smiCauseHub (
    .clk(clk), .rstN(rstN), .causeIn(causeIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .smiOut(smiOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [15:0] rd;
    logic [7:0]  pat;
    rstN = 1'b0; causeIn = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    regRead(2'd0, rd); check("R1 enable", rd, 16'h0);
    regRead(2'd1, rd); check("R1 status", rd, 16'h0);
    regRead(2'd2, rd); check("R1 control", rd, 16'h0);
    check("R1 smiOut", {15'h0, smiOut}, 16'h0);

    // R2 enable register, reserved bits read zero
    regWrite(2'd0, 16'hFFFF); regRead(2'd0, rd); check("R2 all-ones", rd, 16'h00FF);
    regWrite(2'd0, 16'h5AA5); regRead(2'd0, rd); check("R2 pattern", rd, 16'h00A5);
    regWrite(2'd0, 16'h0000);

    // R7 control register width
    regWrite(2'd2, 16'hFFFE); regRead(2'd2, rd); check("R7 gate bit0 only", rd, 16'h0000);
    regWrite(2'd2, 16'hFFFF); regRead(2'd2, rd); check("R7 gate readback", rd, 16'h0001);
    regWrite(2'd2, 16'h0000);

    // R3/R4/R5/R8 per cause; enable and gate stay zero
    for (int i = 0; i < 8; i++) begin
      regWrite(2'd1, 16'h0);
      causeIn = 8'(1 << i);
      waitCyc(4);
      regRead(2'd1, rd); check("R3 edge sets bit", rd, 16'(1 << i));
      check("R8 no smi while disabled", {15'h0, smiOut}, 16'h0);
      regWrite(2'd1, 16'hFFFF); regRead(2'd1, rd); check("R5 write one keeps", rd, 16'(1 << i));
      regWrite(2'd1, 16'h0000); regRead(2'd1, rd); check("R5 write zero clears", rd, 16'h0);
      waitCyc(6);
      regRead(2'd1, rd); check("R4 held level no reset", rd, 16'h0);
      causeIn = 8'h0; waitCyc(4);
      regRead(2'd1, rd); check("R4 fall no set", rd, 16'h0);
      causeIn = 8'(1 << i); waitCyc(4);
      regRead(2'd1, rd); check("R4 re-armed", rd, 16'(1 << i));
      causeIn = 8'h0; waitCyc(4);
    end

    // R6 rising edge collides with clearing write
    for (int i = 0; i < 8; i++) begin
      regWrite(2'd1, 16'h0);
      causeIn = 8'(1 << i);
      waitCyc(2);
      regWrite(2'd1, 16'h0);
      regRead(2'd1, rd); check("R6 set wins", rd, 16'(1 << i));
      causeIn = 8'h0; waitCyc(4);
    end

    // R7 sweep over all enable values, two status patterns, both gate values
    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? 8'h00 : 8'h24;
      regWrite(2'd1, 16'h0);
      causeIn = pat; waitCyc(4);
      causeIn = 8'h0; waitCyc(4);
      regRead(2'd1, rd); check("R3 pattern latch", rd, {8'h0, pat});
      for (int g = 0; g < 2; g++) begin
        regWrite(2'd2, 16'(g));
        for (int e = 0; e < 256; e++) begin
          regWrite(2'd0, 16'(e));
          check("R7 smiOut", {15'h0, smiOut},
                {15'h0, (g == 1) && ((pat & 8'(e)) != 8'h0)});
        end
      end
    end

    // R9 unmapped address
    regWrite(2'd0, 16'h0033);
    regWrite(2'd2, 16'h0001);
    regWrite(2'd3, 16'hFFFF);
    regRead(2'd3, rd); check("R9 reads zero", rd, 16'h0);
    regRead(2'd0, rd); check("R9 enable untouched", rd, 16'h0033);
    regRead(2'd1, rd); check("R9 status untouched", rd, 16'h0024);
    regRead(2'd2, rd); check("R9 control untouched", rd, 16'h0001);

    done = 1'b1;
    summary();
  end

endmodule